// File: doc/BRIEF.md
# Secure Address Region Filter

This block screens memory accesses against a table of programmable address windows. It returns, one clock after each request, a permit or deny verdict and the index of the window that decided it. Eight ranged windows, numbered 1 to 8, can be placed anywhere in a 43-bit space at 4 KB granularity. Window 0 is a background window that always applies where no ranged window matches. Each window carries two secure-side direction permissions, an enable bit (ranged windows only) and a per-requester permission word for non-secure traffic.

Software programs the table through a small register port. Every window write lands in a shadow copy. The checker keeps using the active copy until software writes 1 to the commit register, and then the whole shadow copy replaces the active copy in one step. Software confirms that the commit has finished by reading back the attribute words, which always show the active values. A global report register, which takes effect at once, decides whether a denial also raises an error flag, an interrupt-level flag, or both.

Top module: `sec_region_filter`

## Requirements
- R1: After synchronous reset every window is disabled and every permission is zero, so every check returns deny with region 0, and the region 0 attribute word reads 0x00000001.
- R2: Writes to window registers change only the shadow copy. Check results do not change until a commit. Reading an attribute word (offset 0x64 + 24·n) returns the active value, while base, top and ID words return the shadow value.
- R3: Writing 1 to bit 0 of the commit register (offset 0x34) copies all shadow windows to the active copy on the following clock, and the request then clears by itself. Writing 0 has no effect. The commit register reads as 0.
- R4: Window n (1..8) has its base low/high words at 0x54+24·n and 0x58+24·n and its top low/high words at 0x5C+24·n and 0x60+24·n. Low words hold address bits 31:12 in data bits 31:12, and high words hold address bits 42:32 in data bits 10:0. An enabled window matches when base ≤ address ≤ top at 4 KB granularity. Base low reads back with bits 11:0 zero, and top low reads back with bits 11:0 all ones.
- R5: When several enabled ranged windows match, the highest-numbered one decides.
- R6: When no enabled ranged window matches, window 0 decides. Its base and top words ignore writes and read as 0, its enable bit always reads 1, and only its permission bits can be changed.
- R7: A ranged window whose attribute bit 0 is 0 never matches.
- R8: For a secure access, attribute bit 31 permits writes and attribute bit 30 permits reads.
- R9: A non-secure access also needs a bit of the ID word (offset 0x68 + 24·n): bit id for reads, bit 16+id for writes.
- R10: Report register bits 1:0 sit at offset 0x50 and take effect without a commit. On a denied check, bit 0 raises res_err and bit 1 raises res_irq. A permitted check raises neither.
- R11: res_valid follows chk_valid exactly one clock later, and cfg_rvalid follows a register read exactly one clock later. Checks may arrive back to back on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Register access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 10 | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| chk_valid | input | 1 | Access check request |
| chk_addr | input | 43 | Access address |
| chk_nonsec | input | 1 | Access is non-secure |
| chk_write | input | 1 | Access is a write |
| chk_id | input | 4 | Requester ID |
| res_valid | output | 1 | Verdict valid |
| res_permit | output | 1 | Access permitted |
| res_region | output | 4 | Deciding window index |
| res_err | output | 1 | Denial reported as error |
| res_irq | output | 1 | Denial reported as interrupt |

## Verification
The assertions assume that a register port never writes the commit register while a commit is still pending, and that only one register request is made per cycle. The stimulus issues one bus operation at a time and leaves an idle cycle after every commit. The windows it programs always satisfy base < top with 4 KB-aligned ends, except for one deliberately misaligned base write, which checks that bits 11:0 are discarded. Overlap, a disabled window, unmapped addresses, address bit 42 and all four report settings are each driven while a reference model predicts every output on every cycle.

// File: rtl/sarf_pkg.sv
// Shared constants and types for the secure address region filter.
// Assumes 32-bit register data and byte offsets on the register port.
package sarf_pkg;
    localparam int GRAN_BITS  = 12;     // 4 KB window granularity
    localparam int REG_FIRST  = 'h54;   // first window word (window 0)
    localparam int REG_STRIDE = 'h18;   // bytes per window
    localparam int REPORT_OFS = 'h50;   // global denial-report register
    localparam int COMMIT_OFS = 'h34;   // shadow-to-active commit register

    // Word order inside one window; the register map depends on it.
    typedef enum logic [2:0] {
        FLD_BASE_LO = 3'd0,
        FLD_BASE_HI = 3'd1,
        FLD_TOP_LO  = 3'd2,
        FLD_TOP_HI  = 3'd3,
        FLD_ATTR    = 3'd4,
        FLD_IDS     = 3'd5
    } fld_e;
endpackage

// File: rtl/sarf_regs.sv
// Register file: decodes the register port, holds the shadow and active
// window tables, the commit request and the report setting.
// Assumes ADDR_W > 32, ID_W <= 4 and one register request per cycle.
module sarf_regs
    import sarf_pkg::*;
#(
    parameter int ADDR_W = 43,
    parameter int NREG   = 8,
    parameter int ID_W   = 4,
    parameter int CFG_AW = 10
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cfg_valid,
    input  logic                                      cfg_write,
    input  logic [CFG_AW-1:0]                         cfg_addr,
    input  logic [31:0]                               cfg_wdata,
    output logic                                      cfg_rvalid,
    output logic [31:0]                               cfg_rdata,
    output logic [NREG:1][ADDR_W-GRAN_BITS-1:0]       act_base,
    output logic [NREG:1][ADDR_W-GRAN_BITS-1:0]       act_top,
    output logic [NREG:1]                             act_en,
    output logic [NREG:0][1:0]                        act_sec,
    output logic [NREG:0][2*(1<<ID_W)-1:0]            act_ids,
    output logic [1:0]                                report
);
    localparam int PW   = ADDR_W - GRAN_BITS;
    localparam int HW   = ADDR_W - 32;
    localparam int IDSW = 2 * (1 << ID_W);
    localparam int RW   = $clog2(NREG + 1);

    logic [NREG:1][PW-1:0]   sh_base, sh_top;
    logic [NREG:1]           sh_en;
    logic [NREG:0][1:0]      sh_sec;
    logic [NREG:0][IDSW-1:0] sh_ids;
    logic                    commit_q;

    logic          dec_ok;
    logic [RW-1:0] dec_rgn;
    fld_e          dec_fld;
    logic [31:0]   rd_mux;

    wire is_wr = cfg_valid & cfg_write;
    wire is_rd = cfg_valid & ~cfg_write;

    // Decode the offset into a window index and a word within it.
    always_comb begin
        dec_ok  = 1'b0;
        dec_rgn = '0;
        dec_fld = FLD_BASE_LO;
        for (int n = 0; n <= NREG; n++) begin
            for (int f = 0; f < 6; f++) begin
                if (cfg_addr == CFG_AW'(REG_FIRST + n * REG_STRIDE + 4 * f)) begin
                    dec_ok  = 1'b1;
                    dec_rgn = RW'(n);
                    dec_fld = fld_e'(3'(f));
                end
            end
        end
    end

    // Shadow table, report setting and commit request updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_base  <= '0;
            sh_top   <= '0;
            sh_en    <= '0;
            sh_sec   <= '0;
            sh_ids   <= '0;
            report   <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (is_wr && cfg_addr == CFG_AW'(REPORT_OFS))
                report <= cfg_wdata[1:0];
            if (is_wr && cfg_addr == CFG_AW'(COMMIT_OFS))
                commit_q <= cfg_wdata[0];
            if (is_wr && dec_ok) begin
                case (dec_fld)
                    FLD_BASE_LO: if (dec_rgn != '0) sh_base[dec_rgn][19:0]    <= cfg_wdata[31:12];
                    FLD_BASE_HI: if (dec_rgn != '0) sh_base[dec_rgn][PW-1:20] <= cfg_wdata[HW-1:0];
                    FLD_TOP_LO:  if (dec_rgn != '0) sh_top[dec_rgn][19:0]     <= cfg_wdata[31:12];
                    FLD_TOP_HI:  if (dec_rgn != '0) sh_top[dec_rgn][PW-1:20]  <= cfg_wdata[HW-1:0];
                    FLD_ATTR: begin
                        sh_sec[dec_rgn] <= cfg_wdata[31:30];
                        if (dec_rgn != '0) sh_en[dec_rgn] <= cfg_wdata[0];
                    end
                    default:     sh_ids[dec_rgn] <= cfg_wdata[IDSW-1:0];
                endcase
            end
        end
    end

    // Whole-table copy from shadow to active, one clock after a commit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_base <= '0;
            act_top  <= '0;
            act_en   <= '0;
            act_sec  <= '0;
            act_ids  <= '0;
        end else if (commit_q) begin
            act_base <= sh_base;
            act_top  <= sh_top;
            act_en   <= sh_en;
            act_sec  <= sh_sec;
            act_ids  <= sh_ids;
        end
    end

    // Read-back selection: attributes from the active table, the rest from shadow.
    always_comb begin
        rd_mux = '0;
        if (cfg_addr == CFG_AW'(REPORT_OFS)) begin
            rd_mux = {30'd0, report};
        end else if (dec_ok) begin
            case (dec_fld)
                FLD_BASE_LO: if (dec_rgn != '0) rd_mux = {sh_base[dec_rgn][19:0], 12'h000};
                FLD_BASE_HI: if (dec_rgn != '0) rd_mux = 32'(sh_base[dec_rgn][PW-1:20]);
                FLD_TOP_LO:  if (dec_rgn != '0) rd_mux = {sh_top[dec_rgn][19:0], 12'hFFF};
                FLD_TOP_HI:  if (dec_rgn != '0) rd_mux = 32'(sh_top[dec_rgn][PW-1:20]);
                FLD_ATTR:    rd_mux = {act_sec[dec_rgn], 29'd0,
                                       (dec_rgn == '0) ? 1'b1 : act_en[dec_rgn]};
                default:     rd_mux = 32'(sh_ids[dec_rgn]);
            endcase
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= is_rd;
            cfg_rdata  <= is_rd ? rd_mux : '0;
        end
    end

    // R3: a commit request lasts one clock unless it is written again.
    assert_commit_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_q && !(is_wr && cfg_addr == CFG_AW'(COMMIT_OFS))) |=> !commit_q);

    // R2: the active table holds still whenever no commit is pending.
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_q |=> ($stable(act_base) && $stable(act_top) && $stable(act_en)
                       && $stable(act_sec) && $stable(act_ids)));

    // R6: the background window always reports itself enabled.
    assert_bg_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && dec_ok && dec_rgn == '0 && dec_fld == FLD_ATTR) |=> cfg_rdata[0]);

    // R11: every read returns data on the next clock.
    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> cfg_rvalid);
endmodule

// File: rtl/sarf_match.sv
// Window matcher: finds the highest-numbered enabled ranged window that
// contains the page of the access; 0 means the background window.
// Assumes base and top are page numbers (address >> 12), inclusive.
module sarf_match
    import sarf_pkg::*;
#(
    parameter int ADDR_W = 43,
    parameter int NREG   = 8
) (
    input  logic [ADDR_W-GRAN_BITS-1:0]           page,
    input  logic [NREG:1][ADDR_W-GRAN_BITS-1:0]   act_base,
    input  logic [NREG:1][ADDR_W-GRAN_BITS-1:0]   act_top,
    input  logic [NREG:1]                         act_en,
    output logic [$clog2(NREG+1)-1:0]             win
);
    localparam int RW = $clog2(NREG + 1);

    logic [NREG:1] hit;

    // One inclusive range comparator per ranged window.
    for (genvar n = 1; n <= NREG; n++) begin : g_cmp
        assign hit[n] = act_en[n] && (page >= act_base[n]) && (page <= act_top[n]);
    end

    // Priority pick: a later (higher) window overrides an earlier one.
    always_comb begin
        win = '0;
        for (int n = 1; n <= NREG; n++)
            if (hit[n]) win = RW'(n);
    end
endmodule

// File: rtl/sarf_decide.sv
// Permission decision for the selected window: direction bit for secure
// traffic, plus the requester's ID bit for non-secure traffic.
// Assumes the ID word holds read bits in the low half, write bits above.
module sarf_decide #(
    parameter int NREG = 8,
    parameter int ID_W = 4
) (
    input  logic [$clog2(NREG+1)-1:0]         win,
    input  logic                              nonsec,
    input  logic                              write,
    input  logic [ID_W-1:0]                   id,
    input  logic [NREG:0][1:0]                act_sec,
    input  logic [NREG:0][2*(1<<ID_W)-1:0]    act_ids,
    output logic                              permit
);
    logic [1:0]                 sec;
    logic [2*(1<<ID_W)-1:0]     ids;
    logic                       dir_ok, id_ok;

    // Select the deciding window's fields and apply both rules.
    always_comb begin
        sec    = act_sec[win];
        ids    = act_ids[win];
        dir_ok = write ? sec[1] : sec[0];
        id_ok  = ids[{write, id}];
        permit = dir_ok && (!nonsec || id_ok);
    end
endmodule

// File: rtl/sec_region_filter.sv
// Secure address region filter top: register port, window matcher and
// permission decision, with a registered verdict one clock after each check.
// Assumes chk_* inputs are stable around the clock edge they are sampled on.
module sec_region_filter
    import sarf_pkg::*;
#(
    parameter int ADDR_W = 43,
    parameter int NREG   = 8,
    parameter int ID_W   = 4,
    parameter int CFG_AW = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_valid,
    input  logic                          cfg_write,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic                          cfg_rvalid,
    output logic [31:0]                   cfg_rdata,
    input  logic                          chk_valid,
    input  logic [ADDR_W-1:0]             chk_addr,
    input  logic                          chk_nonsec,
    input  logic                          chk_write,
    input  logic [ID_W-1:0]               chk_id,
    output logic                          res_valid,
    output logic                          res_permit,
    output logic [$clog2(NREG+1)-1:0]     res_region,
    output logic                          res_err,
    output logic                          res_irq
);
    localparam int PW   = ADDR_W - GRAN_BITS;
    localparam int IDSW = 2 * (1 << ID_W);
    localparam int RW   = $clog2(NREG + 1);

    logic [NREG:1][PW-1:0]   act_base, act_top;
    logic [NREG:1]           act_en;
    logic [NREG:0][1:0]      act_sec;
    logic [NREG:0][IDSW-1:0] act_ids;
    logic [1:0]              report;
    logic [RW-1:0]           win;
    logic                    permit;

    wire unused_page_offset = ^chk_addr[GRAN_BITS-1:0];

    sarf_regs #(.ADDR_W(ADDR_W), .NREG(NREG), .ID_W(ID_W), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .act_base(act_base), .act_top(act_top), .act_en(act_en),
        .act_sec(act_sec), .act_ids(act_ids), .report(report)
    );

    sarf_match #(.ADDR_W(ADDR_W), .NREG(NREG)) u_match (
        .page(chk_addr[ADDR_W-1:GRAN_BITS]),
        .act_base(act_base), .act_top(act_top), .act_en(act_en),
        .win(win)
    );

    sarf_decide #(.NREG(NREG), .ID_W(ID_W)) u_decide (
        .win(win), .nonsec(chk_nonsec), .write(chk_write), .id(chk_id),
        .act_sec(act_sec), .act_ids(act_ids), .permit(permit)
    );

    // Register the verdict and the denial reporting flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_permit <= 1'b0;
            res_region <= '0;
            res_err    <= 1'b0;
            res_irq    <= 1'b0;
        end else begin
            res_valid  <= chk_valid;
            res_permit <= chk_valid & permit;
            res_region <= chk_valid ? win : '0;
            res_err    <= chk_valid & ~permit & report[0];
            res_irq    <= chk_valid & ~permit & report[1];
        end
    end

    // R11: one verdict per check, exactly one clock later.
    assert_verdict_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);
    assert_no_spurious_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);

    // R10: a permitted access is never reported.
    assert_quiet_on_permit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_permit) |-> (!res_err && !res_irq));

    // R5: the deciding window index stays within the table.
    assert_region_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_region <= RW'(NREG)));
endmodule

// File: tb/sec_region_filter_test.sv
`timescale 1ns/1ps
module sec_region_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        chk_valid = 1'b0, chk_nonsec = 1'b0, chk_write = 1'b0;
    logic [42:0] chk_addr = '0;
    logic [3:0]  chk_id = '0;
    logic        res_valid, res_permit, res_err, res_irq;
    logic [3:0]  res_region;

    always #2.5 clk = ~clk;

    sec_region_filter uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_nonsec(chk_nonsec),
        .chk_write(chk_write), .chk_id(chk_id),
        .res_valid(res_valid), .res_permit(res_permit), .res_region(res_region),
        .res_err(res_err), .res_irq(res_irq)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    model_live = 0;

    // Behavioural reference state (pages are address >> 12).
    longint unsigned s_base[9], s_top[9], a_base[9], a_top[9];
    bit              s_en[9], a_en[9];
    bit [1:0]        s_sec[9], a_sec[9];
    bit [31:0]       s_ids[9], a_ids[9];
    bit [1:0]        m_report;
    bit              m_commit;

    bit        e_v, e_permit, e_err, e_irq, e_rv;
    int        e_region;
    bit [31:0] e_rdata;

    function automatic int reg_ofs(int n, int f);
        return 'h54 + 24 * n + 4 * f;
    endfunction

    function automatic bit [31:0] model_read(int o);
        int n, f;
        if (o == 'h50) return {30'd0, m_report};
        if (o < 'h54 || ((o - 'h54) % 4) != 0 || ((o - 'h54) / 24) > 8) return 32'd0;
        n = (o - 'h54) / 24;
        f = ((o - 'h54) % 24) / 4;
        case (f)
            0: return (n == 0) ? 32'd0 : 32'((s_base[n] & 64'hFFFFF) << 12);
            1: return 32'(s_base[n] >> 20);
            2: return (n == 0) ? 32'd0 : 32'(((s_top[n] & 64'hFFFFF) << 12) | 64'hFFF);
            3: return 32'(s_top[n] >> 20);
            4: return {a_sec[n], 29'd0, (n == 0) ? 1'b1 : a_en[n]};
            default: return s_ids[n];
        endcase
    endfunction

    task automatic model_write(int o, bit [31:0] d);
        int n, f;
        if (o == 'h50) m_report = d[1:0];
        if (o == 'h34) m_commit = d[0];
        if (o < 'h54 || ((o - 'h54) % 4) != 0 || ((o - 'h54) / 24) > 8) return;
        n = (o - 'h54) / 24;
        f = ((o - 'h54) % 24) / 4;
        case (f)
            0: if (n != 0) s_base[n] = (s_base[n] & ~64'hFFFFF) | 64'(d[31:12]);
            1: if (n != 0) s_base[n] = (s_base[n] & 64'hFFFFF) | (64'(d[10:0]) << 20);
            2: if (n != 0) s_top[n]  = (s_top[n]  & ~64'hFFFFF) | 64'(d[31:12]);
            3: if (n != 0) s_top[n]  = (s_top[n]  & 64'hFFFFF) | (64'(d[10:0]) << 20);
            4: begin s_sec[n] = d[31:30]; if (n != 0) s_en[n] = d[0]; end
            default: s_ids[n] = d;
        endcase
    endtask

    // Reference model: predicts the outputs that appear after this edge.
    always @(posedge clk) begin
        longint unsigned pg;
        int  w;
        bit  ok;
        model_live = 1;
        if (!rst_n) begin
            for (int n = 0; n < 9; n++) begin
                s_base[n] = 0; s_top[n] = 0; a_base[n] = 0; a_top[n] = 0;
                s_en[n] = 0; a_en[n] = 0; s_sec[n] = 0; a_sec[n] = 0;
                s_ids[n] = 0; a_ids[n] = 0;
            end
            m_report = 0; m_commit = 0;
            e_v = 0; e_permit = 0; e_region = 0; e_err = 0; e_irq = 0;
            e_rv = 0; e_rdata = 0;
        end else begin
            e_v = chk_valid; e_permit = 0; e_region = 0; e_err = 0; e_irq = 0;
            if (chk_valid) begin
                pg = 64'(chk_addr) >> 12;
                w = 0;
                for (int n = 1; n <= 8; n++)
                    if (a_en[n] && pg >= a_base[n] && pg <= a_top[n]) w = n;
                ok = chk_write ? a_sec[w][1] : a_sec[w][0];
                if (chk_nonsec) ok = ok && a_ids[w][(chk_write ? 16 : 0) + int'(chk_id)];
                e_permit = ok; e_region = w;
                e_err = !ok && m_report[0];
                e_irq = !ok && m_report[1];
            end
            e_rv = cfg_valid && !cfg_write;
            e_rdata = e_rv ? model_read(int'(cfg_addr)) : 32'd0;
            if (m_commit) begin
                for (int n = 0; n < 9; n++) begin
                    a_base[n] = s_base[n]; a_top[n] = s_top[n]; a_en[n] = s_en[n];
                    a_sec[n] = s_sec[n]; a_ids[n] = s_ids[n];
                end
            end
            m_commit = 0;
            if (cfg_valid && cfg_write) model_write(int'(cfg_addr), cfg_wdata);
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (model_live) begin
            checks++;
            if (res_valid !== e_v || (e_v && (res_permit !== e_permit ||
                int'(res_region) != e_region || res_err !== e_err || res_irq !== e_irq))) begin
                errors++;
                $display("FAIL %s verdict: actual v=%0b p=%0b r=%0d e=%0b i=%0b expected v=%0b p=%0b r=%0d e=%0b i=%0b",
                         cur_req, res_valid, res_permit, res_region, res_err, res_irq,
                         e_v, e_permit, e_region, e_err, e_irq);
            end
            checks++;
            if (cfg_rvalid !== e_rv || (e_rv && cfg_rdata !== e_rdata)) begin
                errors++;
                $display("FAIL %s read: actual v=%0b d=%h expected v=%0b d=%h",
                         cur_req, cfg_rvalid, cfg_rdata, e_rv, e_rdata);
            end
        end
    end

    task automatic bus_wr(int a, bit [31:0] d);
        cfg_valid = 1; cfg_write = 1; cfg_addr = 10'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0;
    endtask

    task automatic bus_rd(int a);
        cfg_valid = 1; cfg_write = 0; cfg_addr = 10'(a);
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic chk(longint unsigned a, bit ns, bit wr, int id);
        chk_valid = 1; chk_addr = 43'(a); chk_nonsec = ns; chk_write = wr; chk_id = 4'(id);
        @(negedge clk);
        chk_valid = 0;
    endtask

    task automatic commit();
        bus_wr('h34, 32'd1);
        @(negedge clk);
    endtask

    task automatic set_region(int n, longint unsigned b, longint unsigned t,
                              bit [1:0] sec, bit en, bit [31:0] ids);
        bus_wr(reg_ofs(n, 0), 32'(b));
        bus_wr(reg_ofs(n, 1), 32'(b >> 32));
        bus_wr(reg_ofs(n, 2), 32'(t));
        bus_wr(reg_ofs(n, 3), 32'(t >> 32));
        bus_wr(reg_ofs(n, 4), {sec, 29'd0, en});
        bus_wr(reg_ofs(n, 5), ids);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk(64'h10000, 0, 0, 0);
        chk(64'h10000, 1, 1, 3);
        bus_rd(reg_ofs(0, 4));
        bus_rd(reg_ofs(3, 4));

        // R2: shadow only until commit
        cur_req = "R2";
        set_region(1, 64'h10000, 64'h1FFFF, 2'b11, 1, 32'hFFFF_FFFF);
        chk(64'h15000, 0, 0, 0);
        bus_rd(reg_ofs(1, 4));
        bus_rd(reg_ofs(1, 0));
        bus_rd(reg_ofs(1, 5));

        // R3: commit copies the whole table
        cur_req = "R3";
        commit();
        chk(64'h15000, 0, 0, 0);
        bus_rd(reg_ofs(1, 4));
        bus_rd('h34);
        bus_wr(reg_ofs(1, 4), {2'b00, 29'd0, 1'b1});
        bus_wr('h34, 32'd0);
        @(negedge clk);
        chk(64'h15000, 0, 1, 0);
        bus_wr(reg_ofs(1, 4), {2'b11, 29'd0, 1'b1});
        commit();

        // R4: inclusive page bounds, alignment, high address bits
        cur_req = "R4";
        chk(64'h10000, 0, 0, 0);
        chk(64'h1FFFF, 0, 0, 0);
        chk(64'hFFFF, 0, 0, 0);
        chk(64'h20000, 0, 0, 0);
        bus_wr(reg_ofs(2, 0), 32'h0003_0ABC);
        bus_rd(reg_ofs(2, 0));
        bus_rd(reg_ofs(1, 2));
        set_region(2, 64'h400_0000_0000, 64'h400_0001_FFFF, 2'b01, 1, 32'h0);
        commit();
        chk(64'h400_0001_F000, 0, 0, 0);
        chk(64'h400_0002_0000, 0, 0, 0);
        chk(64'h000_0001_0000, 0, 0, 0);
        bus_rd(reg_ofs(2, 1));
        bus_rd(reg_ofs(2, 3));

        // R5: highest-numbered overlapping window decides
        cur_req = "R5";
        set_region(3, 64'h18000, 64'h27FFF, 2'b01, 1, 32'h0);
        commit();
        chk(64'h18000, 0, 1, 0);
        chk(64'h17FFF, 0, 1, 0);
        chk(64'h25000, 0, 0, 0);

        // R6: background window
        cur_req = "R6";
        chk(64'h7000_0000, 0, 0, 0);
        bus_wr(reg_ofs(0, 4), {2'b11, 29'd0, 1'b0});
        bus_wr(reg_ofs(0, 0), 32'h0005_0000);
        bus_wr(reg_ofs(0, 2), 32'h0006_0000);
        commit();
        bus_rd(reg_ofs(0, 0));
        bus_rd(reg_ofs(0, 2));
        bus_rd(reg_ofs(0, 4));
        chk(64'h7000_0000, 0, 0, 0);
        chk(64'h5_5000, 0, 1, 0);

        // R7: disabled window never matches
        cur_req = "R7";
        bus_wr(reg_ofs(3, 4), {2'b01, 29'd0, 1'b0});
        commit();
        chk(64'h18000, 0, 1, 0);
        chk(64'h22000, 0, 1, 0);
        bus_rd(reg_ofs(3, 4));

        // R8: secure direction bits
        cur_req = "R8";
        set_region(4, 64'h80000, 64'h8FFFF, 2'b10, 1, 32'h0);
        commit();
        chk(64'h80000, 0, 0, 0);
        chk(64'h80000, 0, 1, 0);
        chk(64'h42000, 0, 0, 0);
        chk(64'h42000, 0, 1, 0);

        // R9: non-secure needs the ID bit
        cur_req = "R9";
        bus_wr(reg_ofs(1, 5), (32'h1 << 5) | (32'h1 << (16 + 9)));
        commit();
        chk(64'h11000, 1, 0, 5);
        chk(64'h11000, 1, 0, 9);
        chk(64'h11000, 1, 1, 9);
        chk(64'h11000, 1, 1, 5);
        chk(64'h11000, 0, 1, 5);
        chk(64'h81000, 1, 1, 0);

        // R10: denial reporting, immediate effect
        cur_req = "R10";
        for (int r = 0; r < 4; r++) begin
            bus_wr('h50, 32'(r));
            chk(64'h80000, 0, 0, 0);
            chk(64'h80000, 0, 1, 0);
            bus_rd('h50);
        end

        // R11: back-to-back checks and reads
        cur_req = "R11";
        for (int k = 0; k < 24; k++) begin
            chk_valid = 1;
            chk_addr = 43'(64'h8000 * k);
            chk_nonsec = k[0]; chk_write = k[1]; chk_id = 4'(k);
            @(negedge clk);
        end
        chk_valid = 0;
        for (int n = 0; n < 9; n++) bus_rd(reg_ofs(n, 4));
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule